// File: doc/BRIEF.md
# Chunked Hash Job Sequencer

This block accepts one hashing job (a 40-bit source address and a byte length) and runs it on an external hash core as a series of chunk operations. It first checks the request. Jobs with a zero length, a length above the maximum, or a null address are refused without touching the core. For a valid job it computes the message length in bits and cuts the message into chunks of a fixed size, `CHUNK_BYTES`, which defaults to 32 × 65535 bytes. For each chunk it clears the core's pending status and then pulses a start command. The command carries the chunk address, the byte count and a final-chunk flag, and it selects either a fresh hash state or a continuation from the digest of the previous chunk. The block also drives a running count of the message bits still to come.

After each start the block waits, for at most a programmable number of cycles, for the core to report completion. It then judges the result from three core indications: done, idle and a 32-bit error word. It continues with the next chunk, or it stops early and reports timeout or error. Each job ends with a one-cycle `job_done` pulse and a 2-bit status code.

The control is one state machine:

| State | Role |
|---|---|
| IDLE | Ready for a job. An accepted bad job goes to REPORT; an accepted good job goes to CLEAR. |
| CLEAR | Pulses `core_status_clr` and latches the next chunk's command, then goes to START. |
| START | Pulses `core_start`, then goes to WAIT. |
| WAIT | A good completion goes to CLEAR while bytes remain, or to REPORT once none remain. A bad completion or an expired wait goes to REPORT. |
| REPORT | Pulses `job_done`, then returns to IDLE. |

Top module: `hash_job_seq`

## Requirements
- R1: `job_ready` is 1 only in IDLE. A job is taken when `job_valid` and `job_ready` are both 1 at a clock edge. A `job_valid` pulse while a job is running has no effect on the commands or the result.
- R2: A job is refused in each of three cases: `job_len` is 0, `job_len` is greater than `MAX_LEN`, or `job_addr` is 0. A refused job gets a `job_done` pulse with status 1 in the cycle after acceptance, and no `core_start` is issued.
- R3: Chunk k (counted from 0) covers the bytes still outstanding, `len - k*CHUNK_BYTES`. When fewer than `CHUNK_BYTES` bytes are outstanding, the byte count is that number and `cmd_last` is 1. Otherwise the byte count is `CHUNK_BYTES` and `cmd_last` is 0. The job ends once no bytes remain, so it issues ceil(len / `CHUNK_BYTES`) starts. A length that is an exact multiple of the chunk size therefore never raises `cmd_last`.
- R4: `cmd_init_hash` is 1 on the first start of a job and 0 on every later start.
- R5: The chunk address is `job_addr + k*CHUNK_BYTES`, computed in 40 bits. `cmd_addr_lo` carries address bits 31:0. `cmd_addr_hi` carries address bits 39:32 in bits 31:24 and the 24-bit chunk byte count in bits 23:0.
- R6: `msg_len_lo` and `msg_len_hi` are the low and high 32-bit words of `len*8`.
- R7: `msg_bits_left` starts at the low word of `len*8`. Before each later chunk it is updated. If it is at most `CHUNK_BYTES*8`, it becomes `(len mod CHUNK_BYTES)*8`. Otherwise it is reduced by `CHUNK_BYTES*8`.
- R8: Each `core_start` comes in the cycle right after a one-cycle `core_status_clr` pulse.
- R9: `irq_enable` is 0x1A during CLEAR, START and WAIT, and 0 in all other states.
- R10: When `core_done` is seen in WAIT, the checks are applied in order. If `core_idle` is 0, the status is timeout (2). Otherwise, if `core_err` is nonzero, the status is error (3). Otherwise the chunk succeeded. A job whose chunks all succeed ends with status 0.
- R11: WAIT lasts at most `timeout_limit`+1 cycles. A `core_done` seen in WAIT cycle i (counted from 0) is accepted when i ≤ `timeout_limit`. If it has not been seen by then, the job ends with status timeout (2).
- R12: A timeout or error skips all remaining chunks. Every job ends with exactly one single-cycle `job_done`, and `job_status` is valid in that cycle.
- R13: The command outputs (`cmd_addr_lo`, `cmd_addr_hi`, `cmd_last`, `cmd_init_hash`, `msg_bits_left`) hold steady from the `core_start` cycle until `core_done` is seen or the job ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| job_valid | input | 1 | Job request |
| job_ready | output | 1 | Ready to accept a job |
| job_addr | input | 40 | Source address of the message |
| job_len | input | 32 | Message length in bytes |
| timeout_limit | input | TIMER_W | Per-chunk wait limit in cycles |
| core_status_clr | output | 1 | Clears the core's pending status |
| core_start | output | 1 | Start pulse for one chunk |
| cmd_addr_lo | output | 32 | Chunk address bits 31:0 |
| cmd_addr_hi | output | 32 | Address bits 39:32 and 24-bit byte count |
| cmd_last | output | 1 | Final-chunk flag |
| cmd_init_hash | output | 1 | Fresh hash state (1) or continuation (0) |
| msg_len_lo | output | 32 | Message length in bits, low word |
| msg_len_hi | output | 32 | Message length in bits, high word |
| msg_bits_left | output | 32 | Bits still to be hashed |
| irq_enable | output | 32 | Interrupt enable mask for the core |
| core_done | input | 1 | Core operation complete |
| core_idle | input | 1 | Core reports idle |
| core_err | input | 32 | Core error status word |
| job_done | output | 1 | One-cycle end-of-job pulse |
| job_status | output | 2 | 0 ok, 1 invalid, 2 timeout, 3 error |

## Verification
The hardest situations to reach from the ports are a fault in the middle of a job and the edges of the wait window. The core model responds after a programmable delay. It can return a nonzero error word or a low idle flag on one chosen chunk. This lets the bench stop a job at a second or third chunk and check that no further starts follow. The bench also runs the delay at exactly `timeout_limit`-1 and at `timeout_limit`. A second job request is fired at every job's first start to show that it is ignored. A small chunk size lets a sweep over every length from 0 to past the maximum reach the exact-multiple, remainder and bits-left corner cases.

// File: rtl/hjs_pkg.sv
package hjs_pkg;

    typedef enum logic [1:0] {
        JS_OK      = 2'd0,
        JS_INVALID = 2'd1,
        JS_TIMEOUT = 2'd2,
        JS_ERROR   = 2'd3
    } job_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CLEAR,
        S_START,
        S_WAIT,
        S_REPORT
    } seq_state_e;

    localparam logic [31:0] IRQ_MASK = 32'h0000_001A;

endpackage

// File: rtl/hjs_validate.sv
module hjs_validate #(
    parameter int          ADDR_W      = 40,
    parameter int          LEN_W       = 32,
    parameter int unsigned MAX_LEN     = 32'h00FF_FFFF,
    parameter int unsigned CHUNK_BYTES = 32 * 65535
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              bad,
    output logic [63:0]       len_bits,
    output logic [31:0]       rem_bits
);
    localparam logic [LEN_W-1:0] CH  = LEN_W'(CHUNK_BYTES);
    localparam logic [LEN_W-1:0] MAXL = LEN_W'(MAX_LEN);

    logic [LEN_W-1:0] rem;

    always_comb begin
        bad      = (len == '0) || (len > MAXL) || (addr == '0);
        len_bits = 64'(len) << 3;
        rem      = len % CH;
        rem_bits = 32'(rem) << 3;
    end
endmodule

// File: rtl/hjs_chunk_step.sv
module hjs_chunk_step #(
    parameter int          LEN_W       = 32,
    parameter int unsigned CHUNK_BYTES = 32 * 65535
) (
    input  logic [LEN_W-1:0] outstanding,
    input  logic [31:0]      bits_left,
    input  logic [31:0]      rem_bits,
    output logic [23:0]      bytes,
    output logic             last,
    output logic [LEN_W-1:0] next_outstanding,
    output logic [31:0]      next_bits_left
);
    localparam logic [LEN_W-1:0] CH      = LEN_W'(CHUNK_BYTES);
    localparam logic [31:0]      CH_BITS = 32'(CHUNK_BYTES * 8);

    always_comb begin
        last             = outstanding < CH;
        bytes            = last ? outstanding[23:0] : CH[23:0];
        next_outstanding = last ? '0 : outstanding - CH;
        next_bits_left   = (bits_left <= CH_BITS) ? rem_bits : bits_left - CH_BITS;
    end
endmodule

// File: rtl/hjs_wait_timer.sv
module hjs_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt <= '0;
        else if (clear)                 cnt <= '0;
        else if (run && cnt != limit)   cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == limit);
endmodule

// File: rtl/hash_job_seq.sv
module hash_job_seq #(
    parameter int          ADDR_W      = 40,
    parameter int          LEN_W       = 32,
    parameter int unsigned MAX_LEN     = 32'h00FF_FFFF,
    parameter int unsigned CHUNK_BYTES = 32 * 65535,
    parameter int          TIMER_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               job_valid,
    output logic               job_ready,
    input  logic [ADDR_W-1:0]  job_addr,
    input  logic [LEN_W-1:0]   job_len,
    input  logic [TIMER_W-1:0] timeout_limit,
    output logic               core_status_clr,
    output logic               core_start,
    output logic [31:0]        cmd_addr_lo,
    output logic [31:0]        cmd_addr_hi,
    output logic               cmd_last,
    output logic               cmd_init_hash,
    output logic [31:0]        msg_len_lo,
    output logic [31:0]        msg_len_hi,
    output logic [31:0]        msg_bits_left,
    output logic [31:0]        irq_enable,
    input  logic               core_done,
    input  logic               core_idle,
    input  logic [31:0]        core_err,
    output logic               job_done,
    output logic [1:0]         job_status
);
    import hjs_pkg::*;

    localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(CHUNK_BYTES);

    seq_state_e        state, state_nx;
    job_status_e       status_r;
    logic [ADDR_W-1:0] next_addr, cmd_addr;
    logic [LEN_W-1:0]  outstanding;
    logic [31:0]       bits_left, rem_bits_r;
    logic [23:0]       cmd_bytes;
    logic              first_r;

    logic              v_bad;
    logic [63:0]       v_len_bits;
    logic [31:0]       v_rem_bits;
    logic [23:0]       s_bytes;
    logic              s_last;
    logic [LEN_W-1:0]  s_next_out;
    logic [31:0]       s_next_bits;
    logic              t_expired;

    hjs_validate #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .CHUNK_BYTES(CHUNK_BYTES)
    ) u_validate (
        .addr(job_addr), .len(job_len), .bad(v_bad),
        .len_bits(v_len_bits), .rem_bits(v_rem_bits)
    );

    hjs_chunk_step #(
        .LEN_W(LEN_W), .CHUNK_BYTES(CHUNK_BYTES)
    ) u_step (
        .outstanding(outstanding), .bits_left(bits_left), .rem_bits(rem_bits_r),
        .bytes(s_bytes), .last(s_last),
        .next_outstanding(s_next_out), .next_bits_left(s_next_bits)
    );

    hjs_wait_timer #(.W(TIMER_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .clear(state == S_START), .run(state == S_WAIT),
        .limit(timeout_limit), .expired(t_expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (job_valid) state_nx = v_bad ? S_REPORT : S_CLEAR;
            S_CLEAR:  state_nx = S_START;
            S_START:  state_nx = S_WAIT;
            S_WAIT: begin
                if (core_done) begin
                    if (!core_idle || core_err != '0) state_nx = S_REPORT;
                    else if (outstanding == '0)       state_nx = S_REPORT;
                    else                              state_nx = S_CLEAR;
                end else if (t_expired) begin
                    state_nx = S_REPORT;
                end
            end
            S_REPORT: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // job and chunk registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_r    <= JS_OK;
            next_addr   <= '0;
            cmd_addr    <= '0;
            outstanding <= '0;
            bits_left   <= '0;
            rem_bits_r  <= '0;
            cmd_bytes   <= '0;
            cmd_last    <= 1'b0;
            cmd_init_hash <= 1'b0;
            first_r     <= 1'b0;
            msg_len_lo  <= '0;
            msg_len_hi  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (job_valid) begin
                    if (v_bad) begin
                        status_r <= JS_INVALID;
                    end else begin
                        next_addr   <= job_addr;
                        outstanding <= job_len;
                        bits_left   <= v_len_bits[31:0];
                        rem_bits_r  <= v_rem_bits;
                        msg_len_lo  <= v_len_bits[31:0];
                        msg_len_hi  <= v_len_bits[63:32];
                        first_r     <= 1'b1;
                    end
                end
                S_CLEAR: begin
                    cmd_addr      <= next_addr;
                    next_addr     <= next_addr + CH_ADDR;
                    cmd_bytes     <= s_bytes;
                    cmd_last      <= s_last;
                    cmd_init_hash <= first_r;
                    first_r       <= 1'b0;
                    outstanding   <= s_next_out;
                    if (!first_r) bits_left <= s_next_bits;
                end
                S_WAIT: begin
                    if (core_done) begin
                        if (!core_idle)             status_r <= JS_TIMEOUT;
                        else if (core_err != '0)    status_r <= JS_ERROR;
                        else                        status_r <= JS_OK;
                    end else if (t_expired) begin
                        status_r <= JS_TIMEOUT;
                    end
                end
                S_START, S_REPORT: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        job_ready       = (state == S_IDLE);
        core_status_clr = (state == S_CLEAR);
        core_start      = (state == S_START);
        job_done        = (state == S_REPORT);
        job_status      = status_r;
        irq_enable      = (state == S_CLEAR || state == S_START || state == S_WAIT)
                          ? IRQ_MASK : 32'h0;
        cmd_addr_lo     = cmd_addr[31:0];
        cmd_addr_hi     = {cmd_addr[ADDR_W-1:32], cmd_bytes};
        msg_bits_left   = bits_left;
    end
endmodule

// File: rtl/hjs_checker.sv
module hjs_checker #(
    parameter int          ADDR_W      = 40,
    parameter int          LEN_W       = 32,
    parameter int unsigned MAX_LEN     = 32'h00FF_FFFF,
    parameter int unsigned CHUNK_BYTES = 32 * 65535
) (
    input logic              clk,
    input logic              rst_n,
    input logic              job_valid,
    input logic              job_ready,
    input logic [ADDR_W-1:0] job_addr,
    input logic [LEN_W-1:0]  job_len,
    input logic              core_status_clr,
    input logic              core_start,
    input logic [31:0]       cmd_addr_lo,
    input logic [31:0]       cmd_addr_hi,
    input logic              cmd_last,
    input logic              cmd_init_hash,
    input logic [31:0]       msg_bits_left,
    input logic              core_done,
    input logic              job_done,
    input logic [1:0]        job_status
);
    localparam logic [23:0] CH24 = 24'(CHUNK_BYTES);

    logic first_pending, waiting;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_pending <= 1'b0;
            waiting       <= 1'b0;
        end else begin
            if (job_valid && job_ready) first_pending <= 1'b1;
            else if (core_start)        first_pending <= 1'b0;
            if (core_start)                  waiting <= 1'b1;
            else if (core_done || job_done)  waiting <= 1'b0;
        end
    end

    assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> !job_ready);

    assert_reject_bad_job_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (job_valid && job_ready &&
         (job_len == '0 || job_len > LEN_W'(MAX_LEN) || job_addr == '0))
        |=> (job_done && job_status == 2'd1 && !core_start));

    assert_last_flag_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> (cmd_addr_hi[23:0] <= CH24) &&
                       (cmd_last == (cmd_addr_hi[23:0] < CH24)));

    assert_init_first_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> (cmd_init_hash == first_pending));

    assert_clear_before_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> $past(core_status_clr));

    assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        job_done |=> !job_done);

    assert_cmd_stable_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (core_start || (waiting && !core_done)) |=>
        ($stable(cmd_addr_lo) && $stable(cmd_addr_hi) && $stable(cmd_last) &&
         $stable(cmd_init_hash) && $stable(msg_bits_left)));
endmodule

bind hash_job_seq hjs_checker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .CHUNK_BYTES(CHUNK_BYTES)
) u_hjs_checker (
    .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_ready(job_ready),
    .job_addr(job_addr), .job_len(job_len), .core_status_clr(core_status_clr),
    .core_start(core_start), .cmd_addr_lo(cmd_addr_lo), .cmd_addr_hi(cmd_addr_hi),
    .cmd_last(cmd_last), .cmd_init_hash(cmd_init_hash), .msg_bits_left(msg_bits_left),
    .core_done(core_done), .job_done(job_done), .job_status(job_status)
);

// File: tb/hash_job_seq_test.sv
module hash_job_seq_test;
    localparam int C    = 8;
    localparam int MAXL = 40;
    localparam int TW   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        job_valid = 1'b0;
    logic        job_ready;
    logic [39:0] job_addr = '0;
    logic [31:0] job_len = '0;
    logic [TW-1:0] timeout_limit = 4'd4;
    logic        core_status_clr, core_start, cmd_last, cmd_init_hash;
    logic [31:0] cmd_addr_lo, cmd_addr_hi, msg_len_lo, msg_len_hi, msg_bits_left, irq_enable;
    logic        core_done = 1'b0;
    logic        core_idle = 1'b1;
    logic [31:0] core_err = '0;
    logic        job_done;
    logic [1:0]  job_status;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    int m_delay = 1;
    logic       m_armed = 1'b0;
    logic [7:0] m_cnt = '0;

    always #5 clk = ~clk;

    hash_job_seq #(
        .ADDR_W(40), .LEN_W(32), .MAX_LEN(MAXL), .CHUNK_BYTES(C), .TIMER_W(TW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_ready(job_ready),
        .job_addr(job_addr), .job_len(job_len), .timeout_limit(timeout_limit),
        .core_status_clr(core_status_clr), .core_start(core_start),
        .cmd_addr_lo(cmd_addr_lo), .cmd_addr_hi(cmd_addr_hi), .cmd_last(cmd_last),
        .cmd_init_hash(cmd_init_hash), .msg_len_lo(msg_len_lo), .msg_len_hi(msg_len_hi),
        .msg_bits_left(msg_bits_left), .irq_enable(irq_enable),
        .core_done(core_done), .core_idle(core_idle), .core_err(core_err),
        .job_done(job_done), .job_status(job_status)
    );

    // core model: done rises m_delay+1 cycles after the start edge, held until cleared
    always @(posedge clk) begin
        if (core_status_clr) core_done <= 1'b0;
        if (core_start) begin
            m_armed <= 1'b1;
            m_cnt   <= 8'(m_delay);
        end else if (m_armed) begin
            if (m_cnt == 0) begin
                core_done <= 1'b1;
                m_armed   <= 1'b0;
            end else begin
                m_cnt <= m_cnt - 1'b1;
            end
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, act=%0d exp=<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors = vectors + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    // bad_kind: 0 none, 1 error word on op bad_op, 2 idle low on op bad_op
    task automatic run_job(input logic [39:0] a, input int len, input int dly,
                           input int bad_op, input int bad_kind, input int lim);
        int n, k, exp_st, exp_starts, outst, bits, remb, ebytes;
        logic elast, bad, finished, garbage;
        logic [39:0] ea;
        bad = (len == 0) || (len > MAXL) || (a == 0);
        n = (len + C - 1) / C;
        if (bad) begin exp_st = 1; exp_starts = 0; end
        else if (dly >= lim) begin exp_st = 2; exp_starts = 1; end
        else if (bad_kind != 0 && bad_op < n) begin
            exp_st = (bad_kind == 1) ? 3 : 2; exp_starts = bad_op + 1;
        end else begin exp_st = 0; exp_starts = n; end

        @(negedge clk);
        m_delay = dly;
        timeout_limit = TW'(lim);
        job_addr = a; job_len = 32'(len); job_valid = 1'b1;
        chk(job_ready == 1'b1, "R1 ready in idle", longint'(job_ready), 1);
        @(negedge clk);
        job_valid = 1'b0;
        k = 0; bits = len * 8; remb = (len % C) * 8; outst = len;
        finished = 1'b0; garbage = 1'b0;
        for (int cyc = 0; cyc < 400 && !finished; cyc++) begin
            if (garbage) begin job_valid = 1'b0; garbage = 1'b0; end
            if (core_start) begin
                if (k > 0) bits = (bits <= C * 8) ? remb : bits - C * 8;
                elast  = outst < C;
                ebytes = elast ? outst : C;
                ea     = a + 40'(k * C);
                chk(cmd_addr_lo == ea[31:0], "R5 addr lo", longint'(cmd_addr_lo), longint'(ea[31:0]));
                chk(cmd_addr_hi == {ea[39:32], 24'(ebytes)}, "R5 addr hi",
                    longint'(cmd_addr_hi), longint'({ea[39:32], 24'(ebytes)}));
                chk(cmd_last == elast, "R3 last flag", longint'(cmd_last), longint'(elast));
                chk(cmd_init_hash == (k == 0), "R4 init select", longint'(cmd_init_hash), longint'(k == 0));
                chk(msg_bits_left == 32'(bits), "R7 bits left", longint'(msg_bits_left), longint'(bits));
                chk(msg_len_lo == 32'(len * 8) && msg_len_hi == 0, "R6 length words",
                    longint'(msg_len_lo), longint'(len * 8));
                chk(irq_enable == 32'h1A, "R9 irq mask", longint'(irq_enable), 32'h1A);
                chk(job_ready == 1'b0, "R1 busy not ready", longint'(job_ready), 0);
                outst = elast ? 0 : outst - C;
                core_idle = !(bad_kind == 2 && k == bad_op);
                core_err  = (bad_kind == 1 && k == bad_op) ? 32'h0000_0004 : 32'h0;
                if (k == 0) begin
                    // R1: request while busy must be ignored
                    job_addr = 40'h1; job_len = 32'd5; job_valid = 1'b1; garbage = 1'b1;
                end
                k++;
            end
            if (job_done) begin
                chk(job_status == 2'(exp_st), "R10 R11 R12 status", longint'(job_status), longint'(exp_st));
                chk(k == exp_starts, "R2 R3 R12 start count", longint'(k), longint'(exp_starts));
                finished = 1'b1;
            end
            @(negedge clk);
        end
        chk(finished == 1'b1, "R12 job completes", longint'(finished), 1);
        chk(job_done == 1'b0, "R12 single pulse", longint'(job_done), 0);
        chk(irq_enable == 32'h0, "R9 mask off in idle", longint'(irq_enable), 0);
        core_idle = 1'b1; core_err = '0; job_valid = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(job_ready == 1'b1 && core_start == 1'b0 && job_done == 1'b0 && irq_enable == 0,
            "R1 reset state", longint'({job_ready, core_start, job_done}), 3'b100);

        // near-exhaustive length sweep, two response delays (R2 R3 R5 R6 R7 R10)
        for (int len = 0; len <= MAXL + 1; len++) begin
            run_job(40'h12_0000_0004, len, 0, 0, 0, 4);
            run_job(40'h12_0000_0004, len, 3, 0, 0, 4);
        end
        // R5 address carry into bits 39:32
        run_job(40'h3A_FFFF_FFF4, 30, 1, 0, 0, 4);
        // R2 null address
        run_job(40'h0, 16, 1, 0, 0, 4);
        // R11 wait window edges
        run_job(40'h55_0000_0100, 20, 2, 0, 0, 3);
        run_job(40'h55_0000_0100, 20, 3, 0, 0, 3);
        run_job(40'h55_0000_0100, 20, 0, 0, 0, 0);
        run_job(40'h55_0000_0100, 20, 15, 0, 0, 15);
        // R10 R12 mid-job faults
        run_job(40'h66_0000_0200, 20, 1, 1, 1, 4);
        run_job(40'h66_0000_0200, 20, 1, 2, 2, 4);
        run_job(40'h66_0000_0200, 20, 1, 0, 2, 4);
        run_job(40'h66_0000_0200, 20, 1, 5, 1, 4);
        // R10 timeout wins over an error word when done never arrives
        run_job(40'h66_0000_0200, 20, 6, 0, 1, 4);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule